// File: doc/BRIEF.md
# Four-Channel Blank-Triggered Memory Copy Engine

This block moves blocks of 16-bit or 32-bit units from one address range to another on behalf of a processor. It has four channels. Each channel holds a programmed source pointer, destination pointer, unit count and a 16-bit control word. A channel starts as soon as it is enabled, or it waits for a vertical-blank or horizontal-blank strobe from the display timing logic. Each address steps up, steps down, holds still, or steps up and returns to its programmed value on every repeat (the last applies to the destination only). A channel may repeat on every trigger and may raise its own interrupt when a run ends.

Software programs a channel through a flat register port addressed by `{channel, select}`. Select 0 is the source, 1 the destination, 2 the count and 3 the control word. The same layout is used for reads. A single memory master performs one read and one write for each unit and waits on a ready handshake. Only one channel runs at a time.

Top module: `dma4_top`

## Requirements
- R1: A write to the source (select 0) or destination (select 1) register stores the value with bit 0 cleared, and reading the register returns that value.
- R2: Every memory access is at least halfword aligned. When control bit 10 is 1 (32-bit units), address bits 1:0 of the latched source and destination are treated as zero.
- R3: A programmed count of 0 means 16384 units on channels 0 to 2 and 65536 units on channel 3. Any other value is the exact number of units.
- R4: The source control (bits 8:7) and destination control (bits 6:5) move their address after each unit as follows: code 0 steps up by the unit size, code 1 steps down, code 2 holds, code 3 steps up. The unit size is 2 bytes, or 4 bytes when bit 10 is 1.
- R5: The start field (bits 13:12) selects the trigger: 0 starts immediately, 1 waits for a vblank strobe, 2 waits for an hblank strobe. Code 3 never starts a transfer, and a strobe of the other kind has no effect.
- R6: Only a 0-to-1 change of the enable bit (bit 15) copies the programmed source, destination and count into the working registers and arms the channel. Rewriting the control word while enable is already 1 keeps the working values.
- R7: When a run without repeat (bit 9 = 0) finishes, the stored control word becomes its old value ANDed with 0x7FE0, so enable and bits 4:0 read back as zero.
- R8: When a run with repeat finishes, the channel stays enabled and waits for its next trigger. The count restarts from the programmed value and the source continues from where it stopped. The destination returns to its programmed value only when destination control is 3.
- R9: When bit 14 is set, the channel's interrupt output pulses high for exactly one cycle, in the cycle after its last write is accepted. When bit 14 is clear, the output does not pulse.
- R10: For each unit the memory port reads the source and then writes the read data to the destination. `mem_wide` shows the unit size, and each access holds its address and direction until `mem_ready` is high.
- R11: Among pending channels the lowest-numbered one is started. A started channel runs to its last unit before any other channel begins.
- R12: If the enable bit is cleared while a channel is armed but not yet started, that channel performs no transfer.
- R13: After reset all registers read as zero, no memory request is made and no interrupt is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address {channel, select} |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address {channel, select} |
| reg_rdata | output | 32 | Read data for reg_raddr |
| vblank | input | 1 | Vertical-blank strobe, one cycle |
| hblank | input | 1 | Horizontal-blank strobe, one cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_wide | output | 1 | 1 for a 32-bit unit, 0 for 16-bit |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, taken when ready is high |
| mem_ready | input | 1 | Completes the current access |
| dma_irq | output | 4 | Per-channel completion pulse |

## Verification
The bench predicts every memory access from its own model of the address modes. It flags any access that arrives out of order or arrives when none is due. This catches a channel that starts on the wrong blank strobe, starts after being cancelled, or reloads its working registers on a control rewrite. Repeat runs are compared run against run: a design that reloads the source, or reloads a non-reloading destination, would put the second run at the wrong addresses. Zero counts are run in full on a small and on the top channel, so swapping the two meanings would either finish early or hang. A lower channel is enabled in the middle of another channel's run, so a design that preempts would interleave accesses.

// File: rtl/dma4_pkg.sv
`timescale 1ns/1ps
package dma4_pkg;

    typedef enum logic [1:0] {
        ADJ_UP        = 2'd0,
        ADJ_DOWN      = 2'd1,
        ADJ_HOLD      = 2'd2,
        ADJ_UP_RELOAD = 2'd3
    } adj_e;

    typedef enum logic [1:0] {
        TRIG_NOW     = 2'd0,
        TRIG_VBL     = 2'd1,
        TRIG_HBL     = 2'd2,
        TRIG_SPECIAL = 2'd3
    } trig_e;

    // control word bit positions (software visible)
    localparam int B_DADJ = 5;
    localparam int B_SADJ = 7;
    localparam int B_RPT  = 9;
    localparam int B_WIDE = 10;
    localparam int B_TRIG = 12;
    localparam int B_IRQ  = 14;
    localparam int B_EN   = 15;

    localparam logic [15:0] END_MASK = 16'h7FE0;

    // signed byte step per unit, two's complement
    function automatic logic [31:0] step_of(adj_e a, logic wide);
        logic [31:0] unit;
        unit = wide ? 32'd4 : 32'd2;
        case (a)
            ADJ_DOWN: step_of = -unit;
            ADJ_HOLD: step_of = 32'd0;
            default:  step_of = unit;
        endcase
    endfunction

endpackage

// File: rtl/dma4_chan.sv
`timescale 1ns/1ps
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int               AW       = 32,
    parameter int               CW       = 17,
    parameter logic [CW-1:0]    ZERO_CNT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [31:0]   wr_data,
    input  logic          vblank,
    input  logic          hblank,
    input  logic          done,
    input  logic [AW-1:0] fin_src,
    input  logic [AW-1:0] fin_dst,
    output logic          pend,
    output logic [15:0]   ctrl,
    output logic [AW-1:0] prog_src,
    output logic [AW-1:0] prog_dst,
    output logic [15:0]   prog_cnt,
    output logic [AW-1:0] work_src,
    output logic [AW-1:0] work_dst,
    output logic [CW-1:0] work_cnt
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [15:0]   cnt;
        logic [15:0]   ctl;
        logic [AW-1:0] wsrc;
        logic [AW-1:0] wdst;
        logic [CW-1:0] wcnt;
        logic          pend;
    } chan_t;

    chan_t q, d;
    logic [CW-1:0] full_cnt;
    trig_e         trig_q;

    always_comb begin
        d        = q;
        full_cnt = (q.cnt == 16'd0) ? ZERO_CNT : CW'(q.cnt);
        trig_q   = trig_e'(q.ctl[B_TRIG+1:B_TRIG]);

        if (wr_en) begin
            case (wr_sel)
                2'd0: d.src = AW'(wr_data) & ~AW'(1);
                2'd1: d.dst = AW'(wr_data) & ~AW'(1);
                2'd2: d.cnt = wr_data[15:0];
                default: begin
                    d.ctl = wr_data[15:0];
                    if (!wr_data[B_EN]) begin
                        d.pend = 1'b0;
                    end else if (!q.ctl[B_EN]) begin
                        d.wsrc = q.src;
                        d.wdst = q.dst;
                        d.wcnt = full_cnt;
                        d.pend = (trig_e'(wr_data[B_TRIG+1:B_TRIG]) == TRIG_NOW);
                    end
                end
            endcase
        end

        if (q.ctl[B_EN] && !q.pend &&
            ((vblank && trig_q == TRIG_VBL) || (hblank && trig_q == TRIG_HBL)))
            d.pend = 1'b1;

        if (done) begin
            d.pend = 1'b0;
            d.wsrc = fin_src;
            d.wcnt = full_cnt;
            if (q.ctl[B_RPT]) begin
                d.wdst = (adj_e'(q.ctl[B_DADJ+1:B_DADJ]) == ADJ_UP_RELOAD) ? q.dst : fin_dst;
                d.pend = (trig_q == TRIG_NOW);
            end else begin
                d.wdst = fin_dst;
                d.ctl  = q.ctl & END_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend     = q.pend;
    assign ctrl     = q.ctl;
    assign prog_src = q.src;
    assign prog_dst = q.dst;
    assign prog_cnt = q.cnt;
    assign work_src = q.wsrc;
    assign work_dst = q.wdst;
    assign work_cnt = q.wcnt;

    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        done && !ctrl[B_RPT] |=> !ctrl[B_EN] && ctrl[4:0] == 5'd0); // R7

    AST_CANCEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd3 && !wr_data[B_EN] && !done |=> !pend); // R12

    AST_NOW_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_sel == 2'd3 && wr_data[B_EN] && !ctrl[B_EN]
        && wr_data[B_TRIG+1:B_TRIG] == 2'd0 && !done |=> pend); // R6

endmodule

// File: rtl/dma4_eng.sv
`timescale 1ns/1ps
module dma4_eng
    import dma4_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int CW  = 17,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCH-1:0]           pend,
    input  logic [NCH-1:0][15:0]     ctl,
    input  logic [NCH-1:0][AW-1:0]   wsrc,
    input  logic [NCH-1:0][AW-1:0]   wdst,
    input  logic [NCH-1:0][CW-1:0]   wcnt,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic                     mem_wide,
    output logic [AW-1:0]            mem_addr,
    output logic [31:0]              mem_wdata,
    input  logic [31:0]              mem_rdata,
    input  logic                     mem_ready,
    output logic [NCH-1:0]           done,
    output logic [AW-1:0]            fin_src,
    output logic [AW-1:0]            fin_dst,
    output logic [NCH-1:0]           irq
);

    typedef enum logic [1:0] {E_IDLE, E_RD, E_WR} est_e;

    typedef struct packed {
        est_e           st;
        logic [CHW-1:0] ch;
        logic [AW-1:0]  src;
        logic [AW-1:0]  dst;
        logic [CW-1:0]  cnt;
        logic           wide;
        adj_e           sadj;
        adj_e           dadj;
        logic           irqen;
        logic [31:0]    data;
        logic [NCH-1:0] irq;
    } eng_t;

    eng_t q, d;
    logic [CHW-1:0] pick;
    logic [15:0]    sel_ctl;
    logic [AW-1:0]  amask, nsrc, ndst;
    logic           unused_ctl;

    always_comb begin
        pick = '0;
        for (int i = NCH - 1; i >= 0; i--)
            if (pend[i]) pick = CHW'(i);
    end

    assign sel_ctl    = ctl[pick];
    assign unused_ctl = ^{sel_ctl[15], sel_ctl[13:11], sel_ctl[9], sel_ctl[4:0]};
    assign amask      = sel_ctl[B_WIDE] ? ~AW'(3) : ~AW'(1);

    always_comb begin
        d        = q;
        d.irq    = '0;
        done     = '0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = q.src;
        nsrc     = q.src + AW'(step_of(q.sadj, q.wide));
        ndst     = q.dst + AW'(step_of(q.dadj, q.wide));
        case (q.st)
            E_IDLE: begin
                if (|pend) begin
                    d.st    = E_RD;
                    d.ch    = pick;
                    d.src   = wsrc[pick] & amask;
                    d.dst   = wdst[pick] & amask;
                    d.cnt   = wcnt[pick];
                    d.wide  = sel_ctl[B_WIDE];
                    d.sadj  = adj_e'(sel_ctl[B_SADJ+1:B_SADJ]);
                    d.dadj  = adj_e'(sel_ctl[B_DADJ+1:B_DADJ]);
                    d.irqen = sel_ctl[B_IRQ];
                end
            end
            E_RD: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    d.data = mem_rdata;
                    d.st   = E_WR;
                end
            end
            default: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = q.dst;
                if (mem_ready) begin
                    d.src = nsrc;
                    d.dst = ndst;
                    d.cnt = q.cnt - CW'(1);
                    d.st  = E_RD;
                    if (q.cnt == CW'(1)) begin
                        done[q.ch]  = 1'b1;
                        d.irq[q.ch] = q.irqen;
                        d.st        = E_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_wide  = q.wide;
    assign mem_wdata = q.data;
    assign fin_src   = nsrc;
    assign fin_dst   = ndst;
    assign irq       = q.irq;

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10

    AST_RD_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $past(mem_req && !mem_we && mem_ready)); // R10

    AST_UNIT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0] && !(mem_wide && mem_addr[1])); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done)); // R11

    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        |irq |-> $past(|done) && $onehot0(irq)); // R9

endmodule

// File: rtl/dma4_top.sv
`timescale 1ns/1ps
module dma4_top
    import dma4_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int AW         = 32,
    parameter int LAST_ZERO  = 65536,
    parameter int OTHER_ZERO = 16384,
    localparam int CHW = $clog2(NCH),
    localparam int CW  = $clog2(LAST_ZERO + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [CHW+1:0]  reg_waddr,
    input  logic [31:0]     reg_wdata,
    input  logic [CHW+1:0]  reg_raddr,
    output logic [31:0]     reg_rdata,
    input  logic            vblank,
    input  logic            hblank,
    output logic            mem_req,
    output logic            mem_we,
    output logic            mem_wide,
    output logic [AW-1:0]   mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ready,
    output logic [NCH-1:0]  dma_irq
);

    logic [NCH-1:0]           pend, done;
    logic [NCH-1:0][15:0]     ctrl, prog_cnt;
    logic [NCH-1:0][AW-1:0]   prog_src, prog_dst, work_src, work_dst;
    logic [NCH-1:0][CW-1:0]   work_cnt;
    logic [AW-1:0]            fin_src, fin_dst;
    logic [CHW-1:0]           rsel;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam logic [CW-1:0] ZC = (i == NCH - 1) ? CW'(LAST_ZERO) : CW'(OTHER_ZERO);
        dma4_chan #(.AW(AW), .CW(CW), .ZERO_CNT(ZC)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_we && reg_waddr[CHW+1:2] == CHW'(i)),
            .wr_sel   (reg_waddr[1:0]),
            .wr_data  (reg_wdata),
            .vblank   (vblank),
            .hblank   (hblank),
            .done     (done[i]),
            .fin_src  (fin_src),
            .fin_dst  (fin_dst),
            .pend     (pend[i]),
            .ctrl     (ctrl[i]),
            .prog_src (prog_src[i]),
            .prog_dst (prog_dst[i]),
            .prog_cnt (prog_cnt[i]),
            .work_src (work_src[i]),
            .work_dst (work_dst[i]),
            .work_cnt (work_cnt[i])
        );
    end

    dma4_eng #(.NCH(NCH), .AW(AW), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .ctl       (ctrl),
        .wsrc      (work_src),
        .wdst      (work_dst),
        .wcnt      (work_cnt),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_wide  (mem_wide),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .done      (done),
        .fin_src   (fin_src),
        .fin_dst   (fin_dst),
        .irq       (dma_irq)
    );

    assign rsel = reg_raddr[CHW+1:2];

    always_comb begin
        case (reg_raddr[1:0])
            2'd0:    reg_rdata = 32'(prog_src[rsel]);
            2'd1:    reg_rdata = 32'(prog_dst[rsel]);
            2'd2:    reg_rdata = 32'(prog_cnt[rsel]);
            default: reg_rdata = 32'(ctrl[rsel]);
        endcase
    end

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_req && dma_irq == '0); // R13

endmodule

// File: tb/tb_dma4_top.sv
`timescale 1ns/1ps
module tb_dma4_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0, reg_raddr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        vblank = 1'b0, hblank = 1'b0;
    logic        mem_req, mem_we, mem_wide, mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  dma_irq;

    dma4_top dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .vblank(vblank), .hblank(hblank),
        .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ready(mem_ready), .dma_irq(dma_irq)
    );

    function automatic logic [31:0] pat(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction
    assign mem_rdata = pat(mem_addr);

    typedef struct {
        bit          we;
        logic [31:0] addr;
        logic [31:0] data;
        bit          wide;
        int          ch;
        bit          last;
        bit          irq;
        string       req;
    } acc_t;

    acc_t        expq[$];
    int          checks = 0, fails = 0;
    bit          rdy_rand = 1'b1;
    logic [15:0] lfsr = 16'hACE1;
    logic [3:0]  irq_exp = '0;
    logic [3:0]  irq_nxt;
    acc_t        cur;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-clock reference comparison
    always @(negedge clk) begin
        if (rst_n) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mem_ready = rdy_rand ? (lfsr[0] | lfsr[5]) : 1'b1;
            chk(dma_irq == irq_exp, "R9 interrupt pulse", 64'(dma_irq), 64'(irq_exp));
            irq_nxt = '0;
            if (mem_req && mem_ready) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R5/R12 unexpected access", 64'(mem_addr), 64'hFFFF_FFFF);
                end else begin
                    cur = expq.pop_front();
                    chk(mem_we == cur.we, {cur.req, " R10 direction"}, 64'(mem_we), 64'(cur.we));
                    chk(mem_addr == cur.addr, {cur.req, " address"}, 64'(mem_addr), 64'(cur.addr));
                    chk(mem_wide == cur.wide, {cur.req, " unit size"}, 64'(mem_wide), 64'(cur.wide));
                    if (cur.we)
                        chk(mem_wdata == cur.data, {cur.req, " R10 data"}, 64'(mem_wdata), 64'(cur.data));
                    if (cur.last && cur.irq) irq_nxt[cur.ch] = 1'b1;
                end
            end
            irq_exp = irq_nxt;
        end
    end

    function automatic logic [31:0] stp(input int a, input bit wide);
        int u;
        u = wide ? 4 : 2;
        case (a)
            1:       return -32'(u);
            2:       return 32'd0;
            default: return 32'(u);
        endcase
    endfunction

    task automatic push_run(input int ch, inout logic [31:0] s, inout logic [31:0] d, input int n,
                            input bit wide, input int sa, input int da, input bit irq, input string req);
        for (int k = 0; k < n; k++) begin
            acc_t r, w;
            r.we = 1'b0; r.addr = s; r.data = '0; r.wide = wide; r.ch = ch;
            r.last = 1'b0; r.irq = irq; r.req = req;
            expq.push_back(r);
            w = r; w.we = 1'b1; w.addr = d; w.data = pat(s); w.last = (k == n - 1);
            expq.push_back(w);
            s = s + stp(sa, wide);
            d = d + stp(da, wide);
        end
    endtask

    function automatic logic [15:0] cw(input bit en, input bit irq, input logic [1:0] trig, input bit wide,
                                       input bit rpt, input logic [1:0] sa, input logic [1:0] da,
                                       input logic [4:0] low);
        return {en, irq, trig, 1'b0, wide, rpt, sa, da, low};
    endfunction

    task automatic wreg(input int ch, input int sel, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = 4'(ch * 4 + sel); reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rreg(input int ch, input int sel, output logic [31:0] v);
        @(negedge clk);
        reg_raddr = 4'(ch * 4 + sel);
        #0.5 v = reg_rdata;
    endtask

    task automatic strobe(input bit v, input bit h);
        @(negedge clk);
        vblank = v; hblank = h;
        @(negedge clk);
        vblank = 1'b0; hblank = 1'b0;
    endtask

    task automatic drain();
        while (expq.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000 + 49000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired, expected queue=%0d", expq.size());
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] s, d, v, c;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state
        chk(!mem_req, "R13 no request", 64'(mem_req), 0);
        chk(dma_irq == 0, "R13 irq low", 64'(dma_irq), 0);
        for (int ch = 0; ch < 4; ch++) begin
            rreg(ch, 3, v); chk(v == 0, "R13 control zero", 64'(v), 0);
            rreg(ch, 0, v); chk(v == 0, "R13 source zero", 64'(v), 0);
        end

        // R1, R4, R7, R9: ch0 immediate 16-bit increment
        wreg(0, 0, 32'h0000_0101);
        rreg(0, 0, v); chk(v == 32'h100, "R1 source bit0", 64'(v), 64'h100);
        wreg(0, 1, 32'h0000_2001);
        rreg(0, 1, v); chk(v == 32'h2000, "R1 destination bit0", 64'(v), 64'h2000);
        wreg(0, 2, 32'd4);
        s = 32'h100; d = 32'h2000;
        push_run(0, s, d, 4, 1'b0, 0, 0, 1'b1, "R4 up/up");
        c = 32'(cw(1, 1, 2'd0, 0, 0, 2'd0, 2'd0, 5'h1F));
        wreg(0, 3, c);
        drain();
        rreg(0, 3, v); chk(v == (c & 32'h7FE0), "R7 one-shot control mask", 64'(v), 64'(c & 32'h7FE0));

        // R2, R4: ch1 32-bit, source down, destination held, misaligned pointers
        wreg(1, 0, 32'h0000_3006);
        wreg(1, 1, 32'h0000_4003);
        wreg(1, 2, 32'd3);
        s = 32'h3004; d = 32'h4000;
        push_run(1, s, d, 3, 1'b1, 1, 2, 1'b0, "R2 wide align");
        wreg(1, 3, 32'(cw(1, 0, 2'd0, 1, 0, 2'd1, 2'd2, 5'h0)));
        drain();

        // R5, R8: ch1 vblank repeat with destination reload, ch2 hblank repeat without reload
        wreg(1, 0, 32'h500); wreg(1, 1, 32'h600); wreg(1, 2, 32'd2);
        wreg(2, 0, 32'h7100); wreg(2, 1, 32'h700); wreg(2, 2, 32'd2);
        wreg(1, 3, 32'(cw(1, 1, 2'd1, 0, 1, 2'd0, 2'd3, 5'h0)));
        wreg(2, 3, 32'(cw(1, 1, 2'd2, 0, 1, 2'd2, 2'd0, 5'h0)));
        idle(8);   // R5: nothing may move before a strobe
        s = 32'h7100; d = 32'h700;
        push_run(2, s, d, 2, 1'b0, 2, 0, 1'b1, "R5 hblank ch2");
        strobe(1'b0, 1'b1);
        drain();
        begin
            logic [31:0] s1, d1;
            s1 = 32'h500; d1 = 32'h600;
            push_run(1, s1, d1, 2, 1'b0, 0, 3, 1'b1, "R5 vblank ch1");
            strobe(1'b1, 1'b0);
            drain();
            push_run(2, s, d, 2, 1'b0, 2, 0, 1'b1, "R8 no-reload destination");
            strobe(1'b0, 1'b1);
            drain();
            d1 = 32'h600;
            push_run(1, s1, d1, 2, 1'b0, 0, 3, 1'b1, "R8 reload destination");
            strobe(1'b1, 1'b0);
            drain();
        end
        rreg(1, 3, v); chk(v[15] == 1'b1, "R8 repeat stays enabled", 64'(v[15]), 1);
        // R12: disarm both, strobes do nothing
        wreg(1, 3, 32'h0); wreg(2, 3, 32'h0);
        strobe(1'b1, 1'b1);
        idle(10);

        // R6: rewrite with enable set keeps latched values
        wreg(1, 3, 32'(cw(1, 1, 2'd1, 0, 0, 2'd0, 2'd0, 5'h0)));
        wreg(1, 0, 32'h900); wreg(1, 2, 32'd5);
        wreg(1, 3, 32'(cw(1, 1, 2'd1, 0, 0, 2'd0, 2'd0, 5'h0)));
        s = 32'h500; d = 32'h600;
        push_run(1, s, d, 2, 1'b0, 0, 0, 1'b1, "R6 no reload on rewrite");
        strobe(1'b1, 1'b0);
        drain();
        rreg(1, 3, v); chk(v[15] == 1'b0, "R7 enable cleared", 64'(v[15]), 0);

        // R12: cancel an armed channel
        wreg(2, 3, 32'(cw(1, 1, 2'd2, 0, 0, 2'd0, 2'd0, 5'h0)));
        wreg(2, 3, 32'(cw(0, 1, 2'd2, 0, 0, 2'd0, 2'd0, 5'h0)));
        strobe(1'b0, 1'b1);
        idle(12);

        // R5: special start code on ch0 never runs
        wreg(0, 3, 32'(cw(1, 1, 2'd3, 0, 0, 2'd0, 2'd0, 5'h0)));
        strobe(1'b1, 1'b0); strobe(1'b0, 1'b1);
        idle(12);
        wreg(0, 3, 32'h0);

        // R11: ch2 and ch3 on hblank, ch0 enabled mid-run
        wreg(2, 0, 32'hA000); wreg(2, 1, 32'hB000); wreg(2, 2, 32'd6);
        wreg(3, 0, 32'h8000); wreg(3, 1, 32'h9000); wreg(3, 2, 32'd3);
        wreg(0, 0, 32'hC000); wreg(0, 1, 32'hD000); wreg(0, 2, 32'd2);
        wreg(2, 3, 32'(cw(1, 1, 2'd2, 0, 0, 2'd0, 2'd0, 5'h0)));
        wreg(3, 3, 32'(cw(1, 1, 2'd2, 1, 0, 2'd0, 2'd0, 5'h0)));
        s = 32'hA000; d = 32'hB000;
        push_run(2, s, d, 6, 1'b0, 0, 0, 1'b1, "R11 lowest first ch2");
        s = 32'hC000; d = 32'hD000;
        push_run(0, s, d, 2, 1'b0, 0, 0, 1'b1, "R11 no preempt ch0");
        s = 32'h8000; d = 32'h9000;
        push_run(3, s, d, 3, 1'b1, 0, 0, 1'b1, "R11 last ch3");
        strobe(1'b0, 1'b1);
        idle(2);
        wreg(0, 3, 32'(cw(1, 1, 2'd0, 0, 0, 2'd0, 2'd0, 5'h0)));
        drain();

        // R3: zero count on a small channel and on the top channel
        rdy_rand = 1'b0;
        wreg(1, 0, 32'h1200); wreg(1, 1, 32'h1300); wreg(1, 2, 32'd0);
        s = 32'h1200; d = 32'h1300;
        push_run(1, s, d, 16384, 1'b0, 2, 2, 1'b1, "R3 ch1 zero count");
        wreg(1, 3, 32'(cw(1, 1, 2'd0, 0, 0, 2'd2, 2'd2, 5'h0)));
        drain();
        wreg(3, 0, 32'h1400); wreg(3, 1, 32'h1500); wreg(3, 2, 32'd0);
        s = 32'h1400; d = 32'h1500;
        push_run(3, s, d, 65536, 1'b0, 2, 2, 1'b1, "R3 ch3 zero count");
        wreg(3, 3, 32'(cw(1, 1, 2'd0, 0, 0, 2'd2, 2'd2, 5'h0)));
        drain();
        chk(expq.size() == 0, "R3 all units seen", 64'(expq.size()), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule